// File: doc/BRIEF.md
# I2C controller register and interrupt block

This block is the software-facing register file that sits in front of an I2C master engine. It keeps the two bus-timing words, the configuration word, the target address and two data words. It passes these to the engine as plain output ports. A write to the command register starts a transfer. The engine then reports back a completion pulse with error flags, and may also load received bytes into the data words.

The completion and error flags are latched into a status register. Software clears a status bit by writing a one to it. A level interrupt is raised whenever a latched status bit is also enabled in the mask register. The done flag is set on every completion, whatever the outcome, so enabling that one bit is enough to be told of every result. Software that does not use the interrupt can poll a read-only busy word until it reads zero. The register bus is a simple single-cycle interface: a write is committed at the clock edge and read data is combinational from the word index.

Top module: `i2c_ctl_regs`

## Requirements
- R1: After reset, word 0 and word 1 (the timing words) read 0x0000301F, word 2 (the configuration word) reads 0x00003302, and every other word reads zero.
- R2: Word index is the byte offset divided by four: 0 standard/fast timing, 1 high-speed timing, 2 configuration, 3 command, 4 target address, 5 data low, 6 data high, 7 status, 8 mask, 9 busy. The writable bits are as follows. The timing words keep bits 15:12 (filter) and 9:0 (divider). The configuration word keeps bits 15:0 except 3:2. The command word keeps bits 9:8 (kind), 6:4 (write length minus one) and 2:0 (read length minus one). The target address keeps bits 9:0. The data words keep all 32 bits. Status and mask keep bits 4:0. All other bits read zero, and each stored word appears on its engine port.
- R3: A command write while the busy word reads 0 stores the command and sets busy to 1. In the following cycle only, eng_start pulses high, with the stored kind and lengths on the engine ports.
- R4: A command write while busy is 1 is ignored: the command word keeps its value and no start pulse follows.
- R5: eng_done while busy clears busy. In the same edge it sets status bit 0 (done), and also status bits 1 to 4 from eng_err[0] to eng_err[3] (lost arbitration, no response, data collision, bus busy).
- R6: A status write clears exactly the bits that are one in the written value. A bit being set by a completion in the same cycle stays set.
- R7: irq is high exactly when some status bit is one and its mask bit is one.
- R8: eng_rx_valid loads eng_rx_data[31:0] into data low and eng_rx_data[63:32] into data high. In the same cycle it takes priority over a software write to those words.
- R9: Writes to the busy word have no effect; it reads 1 only during a transfer.
- R10: eng_done while busy is 0 leaves the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access this cycle |
| reg_wr | input | 1 | Access is a write |
| reg_word | input | 4 | Word index (byte offset / 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the indexed word |
| eng_start | output | 1 | One-cycle transfer launch |
| eng_kind | output | 2 | Transfer kind (0 write, 1 read, 2 write-then-read) |
| eng_wlen_m1 | output | 3 | Write byte count minus one |
| eng_rlen_m1 | output | 3 | Read byte count minus one |
| eng_cfg | output | 16 | Configuration word |
| eng_clk_std | output | 16 | Standard/fast timing word |
| eng_clk_hs | output | 16 | High-speed timing word |
| eng_target | output | 10 | Target address |
| eng_tx_data | output | 64 | Data high and low words, high in 63:32 |
| eng_done | input | 1 | Transfer finished pulse |
| eng_err | input | 4 | Error flags valid with eng_done |
| eng_rx_valid | input | 1 | Received data valid |
| eng_rx_data | input | 64 | Received data |
| irq | output | 1 | Level interrupt |

## Verification
Read data depends only on the word index and stored state, so it is sampled 1 ns after the index is driven, in the same cycle. Writes, completions and received data change state at the next rising edge. So status, busy, irq and the engine ports are compared against the reference model at the falling edge that follows. The start pulse is due in the cycle right after the accepting edge, and lasts that one cycle only. The model applies each input at the same edge as the design and is compared at every falling edge. Directed reads of literal values pin down reset, masking, collisions and ignored writes.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
  localparam int NREG  = 10;
  localparam int IDX_W = 4;
  localparam int EVT_W = 5;

  localparam int IDX_CLK_STD = 0;
  localparam int IDX_CLK_HS  = 1;
  localparam int IDX_CFG     = 2;
  localparam int IDX_CMD     = 3;
  localparam int IDX_TADDR   = 4;
  localparam int IDX_DLO     = 5;
  localparam int IDX_DHI     = 6;
  localparam int IDX_STS     = 7;
  localparam int IDX_MSK     = 8;
  localparam int IDX_BUSY    = 9;

  localparam logic [31:0] TIMING_RST = 32'h0000_301F;
  localparam logic [31:0] CFG_RST    = 32'h0000_3302;

  function automatic logic [31:0] word_mask(int idx);
    case (idx)
      IDX_CLK_STD, IDX_CLK_HS: return 32'h0000_F3FF;
      IDX_CFG:                 return 32'h0000_FFF3;
      IDX_CMD:                 return 32'h0000_0377;
      IDX_TADDR:               return 32'h0000_03FF;
      IDX_DLO, IDX_DHI:        return 32'hFFFF_FFFF;
      IDX_STS, IDX_MSK:        return 32'h0000_001F;
      default:                 return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] word_reset(int idx);
    case (idx)
      IDX_CLK_STD, IDX_CLK_HS: return TIMING_RST;
      IDX_CFG:                 return CFG_RST;
      default:                 return 32'h0;
    endcase
  endfunction

  // status update: drop written ones, then add completion flags
  function automatic logic [EVT_W-1:0] next_status(logic [EVT_W-1:0] cur,
                                                   logic [EVT_W-1:0] clr,
                                                   logic [EVT_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/i2c_rb_field.sv
module i2c_rb_field #(
  parameter logic [31:0] RST     = 32'h0,
  parameter logic [31:0] MASK    = 32'hFFFF_FFFF,
  parameter bit          HW_LOAD = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  input  logic        hw_ld,
  input  logic [31:0] hw_data,
  output logic [31:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              q <= RST & MASK;
    else if (HW_LOAD && hw_ld) q <= hw_data & MASK;
    else if (we)             q <= wdata & MASK;
  end
endmodule

// File: rtl/i2c_rb_launch.sv
module i2c_rb_launch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [9:0] cmd_wdata,
  input  logic       eng_done,
  output logic [9:0] cmd_q,
  output logic       busy,
  output logic       start,
  output logic       cmd_accept
);
  assign cmd_accept = cmd_wr && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      busy  <= 1'b0;
      start <= 1'b0;
    end else begin
      start <= cmd_accept;
      if (cmd_accept) begin
        cmd_q <= cmd_wdata & 10'h377;
        busy  <= 1'b1;
      end else if (eng_done) begin
        busy  <= 1'b0;
      end
    end
  end

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> (start && busy));
  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
  // R4
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> ($stable(cmd_q) && !start));
endmodule

// File: rtl/i2c_rb_status.sv
module i2c_rb_status
  import i2c_rb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sts_wr,
  input  logic [EVT_W-1:0] sts_wdata,
  input  logic             busy,
  input  logic             eng_done,
  input  logic [3:0]       eng_err,
  input  logic [EVT_W-1:0] msk,
  output logic [EVT_W-1:0] sts,
  output logic             irq
);
  logic             set_evt;
  logic [EVT_W-1:0] set_bits;
  logic [EVT_W-1:0] clr_bits;

  assign set_evt  = eng_done && busy;
  assign set_bits = set_evt ? {eng_err, 1'b1} : '0;
  assign clr_bits = sts_wr ? sts_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else        sts <= next_status(sts, clr_bits, set_bits);
  end

  assign irq = |(sts & msk);

  // R5
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> (sts[0] && (sts[EVT_W-1:1] & $past(eng_err)) == $past(eng_err)));
  // R6
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && !set_evt) |=> ((sts & $past(sts_wdata)) == '0));
  // R10
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !busy && !sts_wr) |=> $stable(sts));
  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(set_evt) || !$stable(msk)));
endmodule

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs
  import i2c_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_word,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              eng_start,
  output logic [1:0]        eng_kind,
  output logic [2:0]        eng_wlen_m1,
  output logic [2:0]        eng_rlen_m1,
  output logic [15:0]       eng_cfg,
  output logic [15:0]       eng_clk_std,
  output logic [15:0]       eng_clk_hs,
  output logic [9:0]        eng_target,
  output logic [63:0]       eng_tx_data,
  input  logic              eng_done,
  input  logic [3:0]        eng_err,
  input  logic              eng_rx_valid,
  input  logic [63:0]       eng_rx_data,
  output logic              irq
);
  logic [31:0]      word_q [NREG];
  logic [NREG-1:0]  word_we;
  logic [9:0]       cmd_q;
  logic             busy;
  logic             cmd_accept;
  logic [EVT_W-1:0] sts;

  always_comb begin
    for (int i = 0; i < NREG; i++)
      word_we[i] = reg_sel && reg_wr && (reg_word == i[IDX_W-1:0]);
  end

  for (genvar g = 0; g < NREG; g++) begin : g_word
    if (g == IDX_CMD) begin : g_cmd
      assign word_q[g] = {22'b0, cmd_q};
    end else if (g == IDX_STS) begin : g_sts
      assign word_q[g] = {{(32-EVT_W){1'b0}}, sts};
    end else if (g == IDX_BUSY) begin : g_busy
      assign word_q[g] = {31'b0, busy};
    end else begin : g_plain
      i2c_rb_field #(
        .RST     (word_reset(g)),
        .MASK    (word_mask(g)),
        .HW_LOAD (g == IDX_DLO || g == IDX_DHI)
      ) u_field (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (word_we[g]),
        .wdata   (reg_wdata),
        .hw_ld   (eng_rx_valid),
        .hw_data ((g == IDX_DHI) ? eng_rx_data[63:32] : eng_rx_data[31:0]),
        .q       (word_q[g])
      );
    end
  end

  i2c_rb_launch u_launch (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (word_we[IDX_CMD]),
    .cmd_wdata  (reg_wdata[9:0]),
    .eng_done   (eng_done),
    .cmd_q      (cmd_q),
    .busy       (busy),
    .start      (eng_start),
    .cmd_accept (cmd_accept)
  );

  i2c_rb_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .sts_wr    (word_we[IDX_STS]),
    .sts_wdata (reg_wdata[EVT_W-1:0]),
    .busy      (busy),
    .eng_done  (eng_done),
    .eng_err   (eng_err),
    .msk       (word_q[IDX_MSK][EVT_W-1:0]),
    .sts       (sts),
    .irq       (irq)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (reg_word == i[IDX_W-1:0]) reg_rdata = word_q[i];
  end

  assign eng_kind    = cmd_q[9:8];
  assign eng_wlen_m1 = cmd_q[6:4];
  assign eng_rlen_m1 = cmd_q[2:0];
  assign eng_cfg     = word_q[IDX_CFG][15:0];
  assign eng_clk_std = word_q[IDX_CLK_STD][15:0];
  assign eng_clk_hs  = word_q[IDX_CLK_HS][15:0];
  assign eng_target  = word_q[IDX_TADDR][9:0];
  assign eng_tx_data = {word_q[IDX_DHI], word_q[IDX_DLO]};

  // R9
  busy_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_we[IDX_BUSY] && !cmd_accept && !eng_done) |=> $stable(busy));
  // R8
  rx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rx_valid |=> (eng_tx_data == $past(eng_rx_data)));
endmodule

// File: tb/i2c_ctl_regs_test.sv
module i2c_ctl_regs_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_sel = 0, reg_wr = 0;
  logic [3:0]  reg_word = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        eng_start, irq;
  logic [1:0]  eng_kind;
  logic [2:0]  eng_wlen_m1, eng_rlen_m1;
  logic [15:0] eng_cfg, eng_clk_std, eng_clk_hs;
  logic [9:0]  eng_target;
  logic [63:0] eng_tx_data;
  logic        eng_done = 0, eng_rx_valid = 0;
  logic [3:0]  eng_err = 0;
  logic [63:0] eng_rx_data = 0;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  i2c_ctl_regs uut (.*);

  // reference model
  logic [31:0] mw [10];
  logic [4:0]  m_sts;
  logic        m_busy, m_start;

  function automatic logic [31:0] bmask(int i);
    case (i)
      0, 1: return 32'hF3FF;
      2: return 32'hFFF3;
      3: return 32'h377;
      4: return 32'h3FF;
      5, 6: return 32'hFFFF_FFFF;
      7, 8: return 32'h1F;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] mval(int i);
    if (i == 7) return {27'b0, m_sts};
    if (i == 9) return {31'b0, m_busy};
    if (i > 9) return 32'h0;
    return mw[i];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mw[i]) mw[i] = 32'h0;
      mw[0] = 32'h301F; mw[1] = 32'h301F; mw[2] = 32'h3302;
      m_sts = 0; m_busy = 0; m_start = 0;
    end else begin
      int idx;
      bit we, done_ok, accept;
      logic [4:0] clr;
      idx = int'(reg_word);
      we = reg_sel && reg_wr;
      done_ok = eng_done && m_busy;
      accept = we && idx == 3 && !m_busy;
      if (we && idx inside {0, 1, 2, 4, 5, 6, 8}) mw[idx] = reg_wdata & bmask(idx);
      if (eng_rx_valid) begin
        mw[5] = eng_rx_data[31:0];
        mw[6] = eng_rx_data[63:32];
      end
      if (accept) mw[3] = reg_wdata & 32'h377;
      clr = (we && idx == 7) ? reg_wdata[4:0] : 5'b0;
      m_sts = (m_sts & ~clr) | (done_ok ? {eng_err, 1'b1} : 5'b0);
      if (accept) m_busy = 1;
      else if (done_ok) m_busy = 0;
      m_start = accept;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison of registered outputs
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R7 irq", irq, |(m_sts & mw[8][4:0]));
      chk("R3 start", eng_start, m_start);
      chk("R3 cmd ports", {eng_kind, eng_wlen_m1, eng_rlen_m1}, {mw[3][9:8], mw[3][6:4], mw[3][2:0]});
      chk("R2 ports", {eng_cfg, eng_clk_std, eng_clk_hs, eng_target},
          {mw[2][15:0], mw[0][15:0], mw[1][15:0], mw[4][9:0]});
      chk("R8 tx data", eng_tx_data, {mw[6], mw[5]});
    end
  end

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_word = idx[3:0]; reg_wdata = d;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0;
  endtask

  task automatic rd(int idx, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_sel = 1; reg_wr = 0; reg_word = idx[3:0];
    #1;
    chk(tag, reg_rdata, exp);
    chk({tag, " model"}, reg_rdata, mval(idx));
    reg_sel = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset values
    rd(0, 32'h301F, "R1 std clk");
    rd(1, 32'h301F, "R1 hs clk");
    rd(2, 32'h3302, "R1 cfg");
    for (int i = 3; i < 10; i++) rd(i, 32'h0, "R1 zero word");

    // R2 writable bits
    for (int i = 0; i < 9; i++) if (i != 3 && i != 7) wr(i, 32'hFFFF_FFFF);
    rd(0, 32'hF3FF, "R2 std clk mask");
    rd(2, 32'hFFF3, "R2 cfg mask");
    rd(4, 32'h3FF, "R2 addr mask");
    rd(6, 32'hFFFF_FFFF, "R2 data hi");
    rd(8, 32'h1F, "R2 mask reg");
    // R9 busy word read-only
    wr(9, 32'hFFFF_FFFF);
    rd(9, 32'h0, "R9 busy ignores write");
    wr(8, 32'h1);

    // R3 launch
    wr(3, 32'hFFFF_FA15);
    chk("R3 start pulse", eng_start, 1'b1);
    chk("R3 kind/len", {eng_kind, eng_wlen_m1, eng_rlen_m1}, {2'd2, 3'd1, 3'd5});
    rd(3, 32'h215, "R3 cmd readback");
    chk("R3 single pulse", eng_start, 1'b0);
    rd(9, 32'h1, "R3 busy set");
    // R4 ignored while busy
    wr(3, 32'h100);
    chk("R4 no start", eng_start, 1'b0);
    rd(3, 32'h215, "R4 cmd kept");

    // R5 + R8 completion with error and data
    @(negedge clk);
    eng_done = 1; eng_err = 4'b0010; eng_rx_valid = 1;
    eng_rx_data = 64'h0123_4567_89AB_CDEF;
    @(negedge clk);
    eng_done = 0; eng_err = 0; eng_rx_valid = 0;
    chk("R7 irq after done", irq, 1'b1);
    rd(7, 32'h05, "R5 status flags");
    rd(9, 32'h0, "R5 busy cleared");
    rd(5, 32'h89AB_CDEF, "R8 data low");
    rd(6, 32'h0123_4567, "R8 data high");

    // R6 write one to clear
    wr(7, 32'h04);
    rd(7, 32'h01, "R6 partial clear");
    chk("R7 irq still", irq, 1'b1);
    wr(7, 32'h01);
    rd(7, 32'h00, "R6 full clear");
    chk("R7 irq low", irq, 1'b0);

    // R10 done while idle
    @(negedge clk);
    eng_done = 1; eng_err = 4'hF;
    @(negedge clk);
    eng_done = 0; eng_err = 0;
    rd(7, 32'h00, "R10 idle done ignored");

    // R6 set wins over clear in same cycle
    wr(3, 32'h011);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_word = 4'd7; reg_wdata = 32'h1F; eng_done = 1;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0; eng_done = 0;
    rd(7, 32'h01, "R6 set beats clear");

    // R7 mask gating
    wr(8, 32'h02);
    chk("R7 masked off", irq, 1'b0);
    wr(8, 32'h01);
    chk("R7 unmasked", irq, 1'b1);

    // R8 priority over software write
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_word = 4'd5; reg_wdata = 32'hDEAD_BEEF;
    eng_rx_valid = 1; eng_rx_data = 64'h1111_2222_3333_4444;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0; eng_rx_valid = 0;
    rd(5, 32'h3333_4444, "R8 rx priority");

    // mixed stimulus against the model
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      reg_sel = ($urandom % 2) == 0;
      reg_wr = ($urandom % 3) == 0;
      reg_word = 4'($urandom % 11);
      reg_wdata = $urandom;
      eng_done = ($urandom % 4) == 0;
      eng_err = 4'($urandom);
      eng_rx_valid = ($urandom % 8) == 0;
      eng_rx_data = {$urandom, $urandom};
      #1;
      chk("R2 readback", reg_rdata, mval(int'(reg_word)));
    end
    @(negedge clk);
    reg_sel = 0; reg_wr = 0; eng_done = 0; eng_rx_valid = 0;
    @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule